// File: doc/BRIEF.md
# Gap2 Read/Write Timing Sequencer

This block sits in the sector-data path of a floppy disk controller. After a sector ID has been read, the head crosses the Gap2 field before the data sync field arrives. The sequencer counts byte times from the start of Gap2. It then raises one of two levels: the data-separator VCO enable for a read, or the write gate for a write. The byte count at which the level rises depends on the recording mode (conventional, perpendicular at 500 Kbps, or perpendicular at 1 Mbps).

For reads, the VCO is started a small number of bytes ahead of the sync field. This margin covers spindle speed variation. For conventional writes, the gate opens exactly where the sync field starts. A perpendicular drive has a pre-erase head, so for perpendicular writes the gate opens inside Gap2, and a fixed number of bytes is written there before the sync field. The Gap2 length of each mode, the VCO lead and the in-gap write counts are parameters. Each assertion point is derived from them. The operation select and the mode are captured when Gap2 starts. Once a level is raised it stays up until the field ends, the operation is aborted, or a new Gap2 begins.

Top module: `gap2_seq`

## Requirements
- R1: While and after reset (rst_n low), vco_en and wr_gate are low and the sequencer is idle.
- R2: rec_mode is decoded as 2'b00 conventional, 2'b01 perpendicular 500 Kbps, 2'b10 perpendicular 1 Mbps, and 2'b11 as conventional. rec_mode and op_write (1 = write, 0 = read) are sampled only in the cycle gap_start is high. Later changes have no effect on the running field.
- R3: In a read in conventional or 500 Kbps perpendicular mode, vco_en rises in the cycle after the 24th byte_tick counted since gap_start. This count is the Gap2 length of 26 minus the lead of 2.
- R4: In a read in 1 Mbps perpendicular mode, vco_en rises in the cycle after the 43rd counted byte_tick. This count is the Gap2 length of 45 minus the lead of 2.
- R5: In a write in conventional mode, wr_gate rises in the cycle after the 26th counted byte_tick, which is the start of the sync field.
- R6: In a write in either perpendicular mode, wr_gate rises in the cycle after the 7th counted byte_tick. This leaves 19 bytes (500 Kbps, Gap2 of 26) or 38 bytes (1 Mbps, Gap2 of 45) to be written inside Gap2.
- R7: vco_en only rises for a read and wr_gate only rises for a write. The two are never high together.
- R8: Once raised, a level stays high through further byte_ticks until end_field or abort is seen. It is then low from the next cycle on.
- R9: A gap_start pulse clears both levels and restarts the count from zero. A byte_tick in the same cycle as gap_start is not counted.
- R10: byte_ticks that arrive while the sequencer is idle (before any gap_start, or after end_field or abort) are not counted and raise nothing.
- R11: When end_field or abort is high in the same cycle as gap_start, the stop wins and the sequencer stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_tick | input | 1 | One-cycle strobe per byte time on the media |
| gap_start | input | 1 | One-cycle pulse marking the first byte of Gap2 |
| op_write | input | 1 | Operation select: 1 write, 0 read, sampled with gap_start |
| rec_mode | input | 2 | Recording mode code, sampled with gap_start |
| end_field | input | 1 | End of the data field, drops the active level |
| abort | input | 1 | Operation abort, drops the active level |
| vco_en | output | 1 | Data-separator VCO enable level |
| wr_gate | output | 1 | Write gate level |

## Verification
A table walks all four mode codes, each with a read and with a write. In every case the outputs are checked one tick before the expected count, at the count, and a few ticks beyond it. This shows whether each mode and operation pair reaches its own threshold, rather than a neighbouring one or a threshold that is off by one. Directed sequences then cover the following cases:
- idle ticks ahead of a Gap2;
- a restart in mid-count;
- a tick that coincides with gap_start;
- a mode change after capture;
- a stop that collides with a start;
- an abort;
- a reset in mid-gate.

Each of these shows whether the count origin and the captured settings are held correctly.

// File: rtl/gap2_pkg.sv
// Package gap2_pkg
// Shared recording-mode encoding for the Gap2 timing sequencer.
// Assumes the mode code comes from an already-resolved drive/mode decision.
package gap2_pkg;

    typedef enum logic [1:0] {
        RM_CONV     = 2'b00,
        RM_PERP_500 = 2'b01,
        RM_PERP_1M  = 2'b10,
        RM_SPARE    = 2'b11
    } rec_mode_e;

    // Returns the larger of two byte counts, used to size counters.
    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/gap2_thresh_sel.sv
// Module gap2_thresh_sel
// Picks the byte count at which the active level must rise, from the
// recording mode and the operation. Purely combinational.
// Assumes every Gap2 length exceeds both the VCO lead and the in-gap
// write count of its mode, so that no threshold is zero or negative.
module gap2_thresh_sel
    import gap2_pkg::*;
#(
    parameter int unsigned CNT_W          = 6,
    parameter int unsigned CONV_GAP_BYTES = 26,
    parameter int unsigned P500_GAP_BYTES = 26,
    parameter int unsigned P1M_GAP_BYTES  = 45,
    parameter int unsigned VCO_LEAD       = 2,
    parameter int unsigned P500_WR_IN_GAP = 19,
    parameter int unsigned P1M_WR_IN_GAP  = 38
) (
    input  logic [1:0]       mode_i,
    input  logic             write_i,
    output logic [CNT_W-1:0] thr_o
);

    localparam logic [CNT_W-1:0] THR_CONV_RD = CNT_W'(CONV_GAP_BYTES - VCO_LEAD);
    localparam logic [CNT_W-1:0] THR_P500_RD = CNT_W'(P500_GAP_BYTES - VCO_LEAD);
    localparam logic [CNT_W-1:0] THR_P1M_RD  = CNT_W'(P1M_GAP_BYTES  - VCO_LEAD);
    localparam logic [CNT_W-1:0] THR_CONV_WR = CNT_W'(CONV_GAP_BYTES);
    localparam logic [CNT_W-1:0] THR_P500_WR = CNT_W'(P500_GAP_BYTES - P500_WR_IN_GAP);
    localparam logic [CNT_W-1:0] THR_P1M_WR  = CNT_W'(P1M_GAP_BYTES  - P1M_WR_IN_GAP);

    rec_mode_e mode_e;

    // Map the raw code onto the mode type.
    always_comb mode_e = rec_mode_e'(mode_i);

    // Select the threshold for this mode and operation; the spare code acts as conventional.
    always_comb begin
        unique case (mode_e)
            RM_PERP_500: thr_o = write_i ? THR_P500_WR : THR_P500_RD;
            RM_PERP_1M:  thr_o = write_i ? THR_P1M_WR  : THR_P1M_RD;
            default:     thr_o = write_i ? THR_CONV_WR : THR_CONV_RD;
        endcase
    end

endmodule

// File: rtl/gap2_byte_counter.sv
// Module gap2_byte_counter
// Counts byte strobes from a Gap2 start up to a threshold captured at that
// start, and emits a one-cycle hit when the threshold is reached.
// Assumes stop and start are pulses. Stop has priority over start, and
// start has priority over a byte strobe in the same cycle.
module gap2_byte_counter #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             hit_o
);

    logic             active_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] thr_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             cnting;

    // Next count value and whether this cycle advances the count.
    always_comb begin
        cnt_nxt = cnt_q + CNT_W'(1);
        cnting  = active_q && tick_i && !stop_i && !start_i && (cnt_q != thr_q);
    end

    // Hit when this strobe brings the count onto the threshold.
    assign hit_o = cnting && (cnt_nxt == thr_q);

    // Track the active window, the running count and the captured threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            thr_q    <= '0;
        end else if (stop_i) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (start_i) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
            thr_q    <= thr_i;
        end else if (cnting) begin
            cnt_q    <= cnt_nxt;
        end
    end

endmodule

// File: rtl/gap2_gate_ctrl.sv
// Module gap2_gate_ctrl
// Holds the single raised level and steers it to either the VCO enable
// or the write gate, based on the operation captured at the Gap2 start.
// Assumes the hit arrives at most once per field.
module gap2_gate_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic stop_i,
    input  logic write_i,
    input  logic hit_i,
    output logic vco_en_o,
    output logic wr_gate_o
);

    logic on_q;
    logic wr_q;

    // Capture the operation type with each Gap2 start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= 1'b0;
        end else if (start_i && !stop_i) begin
            wr_q <= write_i;
        end
    end

    // Raise the level on a hit and drop it on a stop or a restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_q <= 1'b0;
        end else if (stop_i || start_i) begin
            on_q <= 1'b0;
        end else if (hit_i) begin
            on_q <= 1'b1;
        end
    end

    // Route the level to the output that matches the operation.
    always_comb begin
        vco_en_o  = on_q && !wr_q;
        wr_gate_o = on_q &&  wr_q;
    end

endmodule

// File: rtl/gap2_seq.sv
// Module gap2_seq (top)
// Times the VCO enable for reads and the write gate for writes across the
// Gap2 field, with a byte count that depends on the recording mode.
// Assumes byte_tick, gap_start, end_field and abort are single-cycle
// pulses that are synchronous to clk.
module gap2_seq
    import gap2_pkg::*;
#(
    parameter int unsigned CONV_GAP_BYTES = 26,
    parameter int unsigned P500_GAP_BYTES = 26,
    parameter int unsigned P1M_GAP_BYTES  = 45,
    parameter int unsigned VCO_LEAD       = 2,
    parameter int unsigned P500_WR_IN_GAP = 19,
    parameter int unsigned P1M_WR_IN_GAP  = 38
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_tick,
    input  logic       gap_start,
    input  logic       op_write,
    input  logic [1:0] rec_mode,
    input  logic       end_field,
    input  logic       abort,
    output logic       vco_en,
    output logic       wr_gate
);

    localparam int unsigned MAX_GAP = max2(CONV_GAP_BYTES, max2(P500_GAP_BYTES, P1M_GAP_BYTES));
    localparam int unsigned CNT_W   = $clog2(MAX_GAP + 1);

    logic [CNT_W-1:0] thr;
    logic             hit;
    logic             stop;

    // Either field end or abort terminates the window.
    assign stop = end_field || abort;

    gap2_thresh_sel #(
        .CNT_W          (CNT_W),
        .CONV_GAP_BYTES (CONV_GAP_BYTES),
        .P500_GAP_BYTES (P500_GAP_BYTES),
        .P1M_GAP_BYTES  (P1M_GAP_BYTES),
        .VCO_LEAD       (VCO_LEAD),
        .P500_WR_IN_GAP (P500_WR_IN_GAP),
        .P1M_WR_IN_GAP  (P1M_WR_IN_GAP)
    ) u_sel (
        .mode_i  (rec_mode),
        .write_i (op_write),
        .thr_o   (thr)
    );

    gap2_byte_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (gap_start),
        .stop_i  (stop),
        .tick_i  (byte_tick),
        .thr_i   (thr),
        .hit_o   (hit)
    );

    gap2_gate_ctrl u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (gap_start),
        .stop_i    (stop),
        .write_i   (op_write),
        .hit_i     (hit),
        .vco_en_o  (vco_en),
        .wr_gate_o (wr_gate)
    );

endmodule

// File: rtl/gap2_seq_chk.sv
// Module gap2_seq_chk
// Port-level properties of the Gap2 sequencer, bound into gap2_seq.
module gap2_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic byte_tick,
    input logic gap_start,
    input logic end_field,
    input logic abort,
    input logic vco_en,
    input logic wr_gate
);

    // R7: the two levels are mutually exclusive
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(vco_en && wr_gate));

    // R8: a stop drops both levels on the next cycle
    a_r8_stop_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (end_field || abort) |=> (!vco_en && !wr_gate));

    // R8: a raised level holds while no stop or restart arrives
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((vco_en || wr_gate) && !end_field && !abort && !gap_start)
            |=> ($stable(vco_en) && $stable(wr_gate)));

    // R9: a Gap2 start clears both levels on the next cycle
    a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        gap_start |=> (!vco_en && !wr_gate));

    // R3, R4, R5, R6: a level only rises right after a counted byte strobe
    a_r6_rise_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(vco_en) || $rose(wr_gate)) |-> $past(byte_tick));

endmodule

bind gap2_seq gap2_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_tick (byte_tick),
    .gap_start (gap_start),
    .end_field (end_field),
    .abort     (abort),
    .vco_en    (vco_en),
    .wr_gate   (wr_gate)
);

// File: tb/sim_gap2_seq.sv
// Bench for gap2_seq: a mode/operation table walk, then directed corners.
module sim_gap2_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_tick = 1'b0;
    logic       gap_start = 1'b0;
    logic       op_write = 1'b0;
    logic [1:0] rec_mode = 2'b00;
    logic       end_field = 1'b0;
    logic       abort = 1'b0;
    logic       vco_en;
    logic       wr_gate;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // 200 MHz clock
    always #2.5 clk = ~clk;

    gap2_seq u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_tick (byte_tick),
        .gap_start (gap_start),
        .op_write  (op_write),
        .rec_mode  (rec_mode),
        .end_field (end_field),
        .abort     (abort),
        .vco_en    (vco_en),
        .wr_gate   (wr_gate)
    );

    // Expected thresholds, worked out from the requirements
    localparam int RD_CONV = 26 - 2;  // R3
    localparam int RD_P1M  = 45 - 2;  // R4
    localparam int WR_CONV = 26;      // R5
    localparam int WR_PERP = 26 - 19; // R6, equal to 45 - 38

    // Vector: {mode[1:0], write, expected count[7:0]}
    localparam int NV = 8;
    localparam logic [10:0] VEC [NV] = '{
        {2'b00, 1'b0, 8'(RD_CONV)},
        {2'b01, 1'b0, 8'(RD_CONV)},
        {2'b10, 1'b0, 8'(RD_P1M)},
        {2'b11, 1'b0, 8'(RD_CONV)},
        {2'b00, 1'b1, 8'(WR_CONV)},
        {2'b01, 1'b1, 8'(WR_PERP)},
        {2'b10, 1'b1, 8'(WR_PERP)},
        {2'b11, 1'b1, 8'(WR_CONV)}
    };

    task automatic check(input string req, input logic exp_v, input logic exp_w);
        checks++;
        if (vco_en !== exp_v || wr_gate !== exp_w) begin
            errors++;
            $display("FAIL %s: vco_en=%b wr_gate=%b expected vco_en=%b wr_gate=%b",
                     req, vco_en, wr_gate, exp_v, exp_w);
        end
    endtask

    task automatic start(input logic [1:0] m, input logic w);
        gap_start = 1'b1; rec_mode = m; op_write = w;
        @(negedge clk);
        gap_start = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            byte_tick = 1'b1;
            @(negedge clk);
            byte_tick = 1'b0;
        end
    endtask

    task automatic pulse_end();
        end_field = 1'b1;
        @(negedge clk);
        end_field = 1'b0;
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 1'b0, 1'b0);

        // Table walk over all modes and operations: R2, R3, R4, R5, R6, R7, R8
        for (int v = 0; v < NV; v++) begin
            logic [1:0] m;
            logic       w;
            int         n;
            m = VEC[v][10:9];
            w = VEC[v][8];
            n = int'(VEC[v][7:0]);
            start(m, w);
            ticks(n - 1);
            check("R3/R4/R5/R6 one short", 1'b0, 1'b0);
            ticks(1);
            check(w ? "R5/R6 wr_gate at count (R7)" : "R3/R4 vco_en at count (R7)", !w, w);
            ticks(3);
            check("R8 held", !w, w);
            pulse_end();
            check("R8 end drops", 1'b0, 1'b0);
        end

        // R10: idle ticks are ignored, then a full count is still needed
        ticks(10);
        check("R10 idle ticks", 1'b0, 1'b0);
        start(2'b10, 1'b1);
        ticks(WR_PERP - 1);
        check("R10 count from zero", 1'b0, 1'b0);
        ticks(1);
        check("R10 then R6", 1'b0, 1'b1);

        // R9: a restart after the gate opened clears it and recounts
        start(2'b00, 1'b0);
        check("R9 restart clears", 1'b0, 1'b0);
        ticks(20);
        start(2'b00, 1'b0);
        ticks(RD_CONV - 1);
        check("R9 mid-count restart", 1'b0, 1'b0);
        ticks(1);
        check("R9 restart R3", 1'b1, 1'b0);

        // R9: a tick in the gap_start cycle is not counted
        gap_start = 1'b1; byte_tick = 1'b1; rec_mode = 2'b01; op_write = 1'b1;
        @(negedge clk);
        gap_start = 1'b0; byte_tick = 1'b0;
        ticks(WR_PERP - 1);
        check("R9 coincident tick", 1'b0, 1'b0);
        ticks(1);
        check("R9 coincident tick then R6", 1'b0, 1'b1);

        // R8: abort drops the level
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        check("R8 abort drops", 1'b0, 1'b0);
        ticks(30);
        check("R10 ticks after abort", 1'b0, 1'b0);

        // R2: mode and operation changes after capture have no effect
        start(2'b01, 1'b1);
        rec_mode = 2'b00; op_write = 1'b0;
        ticks(WR_PERP);
        check("R2 captured settings", 1'b0, 1'b1);
        pulse_end();

        // R11: stop and start together leave the block idle
        gap_start = 1'b1; end_field = 1'b1; rec_mode = 2'b01; op_write = 1'b1;
        @(negedge clk);
        gap_start = 1'b0; end_field = 1'b0;
        ticks(30);
        check("R11 stop beats start", 1'b0, 1'b0);

        // R1: a reset in mid-gate clears the output
        start(2'b10, 1'b1);
        ticks(WR_PERP);
        check("R6 before reset", 1'b0, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-gate", 1'b0, 1'b0);
        rst_n = 1'b1;
        ticks(50);
        check("R1 idle after reset", 1'b0, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule